// File: doc/BRIEF.md
# Error-Compensated Parallel Shift-Add Tree

This block adds Q signed partial-sum words of P bits, each carrying its own binary weight, in one combinational pass. Word 0 has weight -2^(Q-1) and word j (j ≥ 1) has weight 2^(Q-1-j), so the block finishes the last step of a distributed-arithmetic inner product. The whole sum is unrolled into a carry-save array of full-adder and half-adder cells that ends in one ripple adder. Only the upper columns, the main part, are built and sent out. The TW lowest columns, the truncation part, are never summed.

The truncation part is not simply discarded. The block counts the ones in the highest truncated column and turns that count into a small compensation value. This value is injected at the least significant main-part column, in the same column as the +1 that completes the two's-complement negation of word 0. A control input selects the plain direct-truncation result instead, for comparison. Optional input and output register stages give a latency of IN_REG + OUT_REG cycles. The defaults are (P, Q, TW) = (12, 6, 5), with a 13-bit result.

Top module: `comp_shift_add_tree`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `out_valid` is 0 and `out_sum` is 0.
- R2: `out_valid` repeats `in_valid` delayed by IN_REG + OUT_REG clock cycles (2 by default). Every accepted word set produces exactly one result, in order.
- R3: With `comp_en` = 0, `out_sum` equals D = (-y0)·2^(Q-1-TW) + Σ_{j≥1} floor(yj·2^(Q-1-j) / 2^TW). Here yj is the signed word at `in_words[j*P +: P]`. The result is read as a two's-complement value.
- R4: With `comp_en` = 1, `out_sum` equals D + ((c + B) >> 1). Here c is the number of ones in column TW-1 of the shifted words 1..Q-1, and B = round(Lmax / 2^TW), where Lmax is the largest value the columns below TW-1 can hold. For the defaults B = 2. All-zero input gives 1 and all-ones words give D + 3.
- R5: Word 0 carries negative weight. y0 = -2^(P-1) with all other words 0 gives +2^(P-2+Q-TW) (2048 by default), with no overflow.
- R6: With `comp_en` = 1 and default parameters, the scaled error S - out·2^TW lies in [-32, +33] for every input. S is the exact weighted sum.
- R7: Over a set of random inputs, the mean absolute error with compensation is smaller than with direct truncation.
- R8: While `out_valid` is 0, `out_sum` keeps its last value, whatever `in_words` and `comp_en` carry.
- R9: Inputs at full positive scale and at full negative scale in every word give the exact R3/R4 values without wrap-around.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Word set on `in_words` is to be summed |
| comp_en | input | 1 | 1: inject compensation carry; 0: direct truncation |
| in_words | input | Q*P | Word j at bits [j*P +: P], signed; word 0 negatively weighted |
| out_valid | output | 1 | `out_sum` holds a new result |
| out_sum | output | P+Q-TW | Signed main-part sum |

## Verification
Two values land in the least significant main-part column in the same pass: the +1 that completes the negation of word 0, and the compensation value derived from the truncated column. Both are provoked together by vectors with a non-zero, full-scale negative or all-ones word 0, while the highest truncated column is empty, full, or half full. The result is judged against an independently computed weighted sum in both modes. Each random vector is applied twice, once with compensation and once without, so the bound on the error and the mean-error comparison come from the same inputs.

// File: rtl/csat_pkg.sv
package csat_pkg;

  // Rows left after one layer of 3:2 compression.
  function automatic int rows_after(input int n);
    return 2 * (n / 3) + (n % 3);
  endfunction

  // Rows present at a given layer of the tree.
  function automatic int rows_at(input int n0, input int lvl);
    int n;
    n = n0;
    for (int i = 0; i < lvl; i++) n = rows_after(n);
    return n;
  endfunction

  // Number of 3:2 layers needed to reach two rows.
  function automatic int tree_levels(input int n0);
    int n;
    int l;
    n = n0;
    l = 0;
    for (int i = 0; i < 64; i++) begin
      if (n > 2) begin
        n = rows_after(n);
        l++;
      end
    end
    return l;
  endfunction

  // Rounded bias: the largest value of the truncated columns below the
  // top truncated column, in units of the main-part LSB.
  function automatic int comp_bias(input int tw);
    longint lmax;
    lmax = 0;
    for (int k = 0; k < tw - 1; k++) lmax += longint'(k + 1) << k;
    return int'((lmax + (longint'(1) << (tw - 1))) >> tw);
  endfunction

endpackage

// File: rtl/csat_cells.sv
module csat_fa (
  input  logic a,
  input  logic b,
  input  logic c,
  output logic s,
  output logic co
);
  assign s  = a ^ b ^ c;
  assign co = (a & b) | (a & c) | (b & c);
endmodule

module csat_ha (
  input  logic a,
  input  logic b,
  output logic s,
  output logic co
);
  assign s  = a ^ b;
  assign co = a & b;
endmodule

// File: rtl/csat_csa.sv
module csat_csa #(
  parameter int W = 13
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic [W-1:0] z,
  output logic [W-1:0] sum,
  output logic [W-1:0] carry
);
  logic [W-1:0] co;

  for (genvar i = 0; i < W; i++) begin : g_bit
    csat_fa u_fa (.a(x[i]), .b(y[i]), .c(z[i]), .s(sum[i]), .co(co[i]));
  end

  // Modular: the carry out of the top column is dropped.
  assign carry = {co[W-2:0], 1'b0};
endmodule

// File: rtl/csat_popcount.sv
module csat_popcount #(
  parameter int N  = 5,
  parameter int CW = 4
) (
  input  logic [N-1:0]  bits,
  output logic [CW-1:0] count
);
  logic [CW-1:0] acc [0:N];

  assign acc[0] = '0;
  for (genvar i = 0; i < N; i++) begin : g_inc
    assign acc[i+1] = acc[i] + CW'(bits[i]);
  end
  assign count = acc[N];
endmodule

// File: rtl/csat_cpa.sv
module csat_cpa #(
  parameter int W = 13
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] s
);
  logic [W-1:0] cy;

  csat_ha u_lsb (.a(a[0]), .b(b[0]), .s(s[0]), .co(cy[0]));
  for (genvar i = 1; i < W; i++) begin : g_rip
    csat_fa u_fa (.a(a[i]), .b(b[i]), .c(cy[i-1]), .s(s[i]), .co(cy[i]));
  end
endmodule

// File: rtl/csat_core.sv
module csat_core
  import csat_pkg::*;
#(
  parameter int P  = 12,
  parameter int Q  = 6,
  parameter int TW = Q - 1,
  localparam int OW = P + Q - TW
) (
  input  logic [Q*P-1:0] words,
  input  logic           comp_en,
  output logic [OW-1:0]  sum
);
  localparam int W      = P + Q;
  localparam int R      = Q + 2;
  localparam int NLV    = tree_levels(R);
  localparam int NEG_SH = Q - 1 - TW;
  localparam int CW     = $clog2(Q) + 1;
  localparam int BIAS   = comp_bias(TW);
  localparam logic [OW-1:0] ONE_ROW = OW'(1) << NEG_SH;

  logic [OW-1:0] lvl [0:NLV][0:R-1];
  logic [Q-2:0]  tp_col;
  logic [CW-1:0] tp_cnt;
  logic [CW:0]   tp_biased;
  logic [OW-1:0] comp_row;

  // Addend rows: word 0 enters inverted (the +1 follows as its own row).
  for (genvar j = 0; j < Q; j++) begin : g_row
    localparam int SH = Q - 1 - j;
    logic [P-1:0] wd;
    logic [W-1:0] ext;
    if (j == 0) begin : g_neg
      assign wd = ~words[j*P +: P];
    end else begin : g_pos
      assign wd = words[j*P +: P];
    end
    assign ext        = {{(W-P){wd[P-1]}}, wd} << SH;
    assign lvl[0][j]  = ext[W-1:TW];
    if (j > 0) begin : g_tp
      assign tp_col[j-1] = ext[TW-1];
    end
  end

  // Compensation taken from the highest truncated column only.
  csat_popcount #(.N(Q-1), .CW(CW)) u_cnt (.bits(tp_col), .count(tp_cnt));
  assign tp_biased = (CW+1)'(tp_cnt) + (CW+1)'(BIAS);
  assign comp_row  = OW'(tp_biased >> 1);

  assign lvl[0][Q]   = ONE_ROW;
  assign lvl[0][Q+1] = comp_en ? comp_row : '0;

  // Carry-save reduction, one generate layer per 3:2 stage.
  for (genvar l = 0; l < NLV; l++) begin : g_lvl
    localparam int N = rows_at(R, l);
    localparam int G = N / 3;
    localparam int M = N % 3;
    for (genvar g = 0; g < G; g++) begin : g_csa
      logic [OW-1:0] s_row;
      logic [OW-1:0] c_row;
      csat_csa #(.W(OW)) u_csa (
        .x(lvl[l][3*g]), .y(lvl[l][3*g+1]), .z(lvl[l][3*g+2]),
        .sum(s_row), .carry(c_row)
      );
      assign lvl[l+1][2*g]   = s_row;
      assign lvl[l+1][2*g+1] = c_row;
    end
    for (genvar m = 0; m < M; m++) begin : g_pass
      assign lvl[l+1][2*G+m] = lvl[l][3*G+m];
    end
    for (genvar k = 2*G + M; k < R; k++) begin : g_zero
      assign lvl[l+1][k] = '0;
    end
  end

  csat_cpa #(.W(OW)) u_cpa (.a(lvl[NLV][0]), .b(lvl[NLV][1]), .s(sum));
endmodule

// File: rtl/comp_shift_add_tree.sv
module comp_shift_add_tree #(
  parameter int P       = 12,
  parameter int Q       = 6,
  parameter int TW      = Q - 1,
  parameter bit IN_REG  = 1'b1,
  parameter bit OUT_REG = 1'b1,
  localparam int OW = P + Q - TW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic           comp_en,
  input  logic [Q*P-1:0] in_words,
  output logic           out_valid,
  output logic [OW-1:0]  out_sum
);
  logic           v_s;
  logic           ce_s;
  logic [Q*P-1:0] w_s;
  logic [OW-1:0]  sum_c;

  if (IN_REG) begin : g_in_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        v_s  <= 1'b0;
        ce_s <= 1'b0;
        w_s  <= '0;
      end else begin
        v_s <= in_valid;
        if (in_valid) begin
          ce_s <= comp_en;
          w_s  <= in_words;
        end
      end
    end
  end else begin : g_in_wire
    assign v_s  = in_valid;
    assign ce_s = comp_en;
    assign w_s  = in_words;
  end

  csat_core #(.P(P), .Q(Q), .TW(TW)) u_core (
    .words(w_s), .comp_en(ce_s), .sum(sum_c)
  );

  if (OUT_REG) begin : g_out_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        out_valid <= 1'b0;
        out_sum   <= '0;
      end else begin
        out_valid <= v_s;
        if (v_s) out_sum <= sum_c;
      end
    end
  end else begin : g_out_wire
    assign out_valid = v_s;
    assign out_sum   = sum_c;
  end
endmodule

// File: rtl/csat_chk.sv
module csat_chk #(
  parameter int P       = 12,
  parameter int Q       = 6,
  parameter int TW      = Q - 1,
  parameter bit IN_REG  = 1'b1,
  parameter bit OUT_REG = 1'b1,
  localparam int OW  = P + Q - TW,
  localparam int LAT = int'(IN_REG) + int'(OUT_REG)
) (
  input logic           clk,
  input logic           rst,
  input logic           in_valid,
  input logic           comp_en,
  input logic [Q*P-1:0] in_words,
  input logic           out_valid,
  input logic [OW-1:0]  out_sum
);
  if (LAT > 0) begin : g_lat
    logic [LAT-1:0] v_d;
    logic [LAT-1:0] zd_d;
    logic [LAT-1:0] zc_d;

    always_ff @(posedge clk) begin
      if (rst) begin
        v_d  <= '0;
        zd_d <= '0;
        zc_d <= '0;
      end else begin
        v_d[0]  <= in_valid;
        zd_d[0] <= in_valid && !comp_en && (in_words == '0);
        zc_d[0] <= in_valid && comp_en && (in_words == '0);
        for (int i = 1; i < LAT; i++) begin
          v_d[i]  <= v_d[i-1];
          zd_d[i] <= zd_d[i-1];
          zc_d[i] <= zc_d[i-1];
        end
      end
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
      rst |=> (!out_valid && out_sum == '0));

    assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
      out_valid == v_d[LAT-1]);

    assert_zero_direct_R3: assert property (@(posedge clk) disable iff (rst)
      (out_valid && zd_d[LAT-1]) |-> (out_sum == '0));

    assert_zero_comp_R4: assert property (@(posedge clk) disable iff (rst)
      (out_valid && zc_d[LAT-1]) |-> (out_sum == OW'(1)));
  end

  if (OUT_REG) begin : g_hold
    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
      !out_valid |-> $stable(out_sum));
  end
endmodule

bind comp_shift_add_tree csat_chk #(
  .P(P), .Q(Q), .TW(TW), .IN_REG(IN_REG), .OUT_REG(OUT_REG)
) u_chk (.*);

// File: tb/test_comp_shift_add_tree.sv
`timescale 1ns/1ps
module test_comp_shift_add_tree;
  localparam int P = 12;
  localparam int Q = 6;
  localparam int TW = 5;
  localparam int OW = P + Q - TW;
  localparam int BIAS_TB = 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic           rst;
  logic           in_valid;
  logic           comp_en;
  logic [Q*P-1:0] in_words;
  logic           out_valid;
  logic [OW-1:0]  out_sum;

  comp_shift_add_tree #(.P(P), .Q(Q), .TW(TW)) i_comp_shift_add_tree (
    .clk(clk), .rst(rst), .in_valid(in_valid), .comp_en(comp_en),
    .in_words(in_words), .out_valid(out_valid), .out_sum(out_sum)
  );

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  longint exp_q[$];
  longint sf_q[$];
  bit     ce_q[$];
  string  tag_q[$];
  bit vh0 = 1'b0;
  bit vh1 = 1'b0;
  logic [OW-1:0] last_out = '0;
  longint abs_c = 0;
  longint abs_d = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void model(input logic [Q*P-1:0] w, output longint sfull,
                                output longint dir, output longint cmp);
    longint y;
    int c;
    c = 0;
    sfull = 0;
    dir = 0;
    for (int j = 0; j < Q; j++) begin
      y = longint'($signed(w[j*P +: P]));
      if (j == 0) begin
        sfull += -y * (longint'(1) << (Q - 1));
        dir   += -y * (longint'(1) << (Q - 1 - TW));
      end else begin
        sfull += y * (longint'(1) << (Q - 1 - j));
        dir   += (y * (longint'(1) << (Q - 1 - j))) >>> TW;
        if (TW - 1 - (Q - 1 - j) >= 0)
          c += int'((y >>> (TW - 1 - (Q - 1 - j))) & 1);
      end
    end
    cmp = dir + longint'((c + BIAS_TB) >> 1);
  endfunction

  task automatic step(input bit v, input logic [Q*P-1:0] w, input bit ce, input string tag);
    longint e, sf, d, cm, act, err;
    bit ce_o;
    string t;
    @(negedge clk);
    chk(out_valid == vh1, "R2", longint'(out_valid), longint'(vh1));
    if (out_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2", 1, 0);
      end else begin
        e = exp_q.pop_front();
        sf = sf_q.pop_front();
        ce_o = ce_q.pop_front();
        t = tag_q.pop_front();
        act = longint'($signed(out_sum));
        chk(act == e, t, act, e);
        err = sf - act * (longint'(1) << TW);
        if (ce_o) begin
          chk(err >= -32 && err <= 33, "R6", err, 0);
          abs_c += (err < 0) ? -err : err;
        end else begin
          abs_d += (err < 0) ? -err : err;
        end
      end
    end else begin
      chk(out_sum == last_out, "R8", longint'(out_sum), longint'(last_out));
    end
    last_out = out_sum;
    vh1 = vh0;
    vh0 = v;
    in_valid = v;
    in_words = w;
    comp_en = ce;
    if (v) begin
      model(w, sf, d, cm);
      exp_q.push_back(ce ? cm : d);
      sf_q.push_back(sf);
      ce_q.push_back(ce);
      tag_q.push_back(tag);
    end
  endtask

  function automatic logic [Q*P-1:0] fill(input logic [P-1:0] v);
    logic [Q*P-1:0] w;
    for (int j = 0; j < Q; j++) w[j*P +: P] = v;
    return w;
  endfunction

  function automatic logic [Q*P-1:0] rnd_words();
    logic [Q*P-1:0] w;
    for (int j = 0; j < Q; j++) w[j*P +: P] = P'($urandom);
    return w;
  endfunction

  initial begin
    logic [Q*P-1:0] w;
    rst = 1'b1;
    in_valid = 1'b0;
    comp_en = 1'b0;
    in_words = '0;
    repeat (3) begin
      @(negedge clk);
      // R1: idle outputs under reset
      chk(!out_valid && out_sum == '0, "R1", longint'(out_sum), 0);
    end
    rst = 1'b0;

    // R3 / R4: zero input, both modes
    step(1'b1, '0, 1'b0, "R3");
    step(1'b1, '0, 1'b1, "R4");
    // R5: negative-weight word alone at full negative scale
    w = '0;
    w[P-1:0] = 12'h800;
    step(1'b1, w, 1'b0, "R5");
    step(1'b1, w, 1'b1, "R5");
    // R9: full scale positive and negative in every word
    step(1'b1, fill(12'h7FF), 1'b0, "R9");
    step(1'b1, fill(12'h7FF), 1'b1, "R9");
    step(1'b1, fill(12'h800), 1'b0, "R9");
    step(1'b1, fill(12'h800), 1'b1, "R9");
    // R4: full truncated column (all ones) plus negation increment
    step(1'b1, fill(12'hFFF), 1'b1, "R4");
    step(1'b1, fill(12'hFFF), 1'b0, "R3");
    // R8: idle cycles with garbage on the inputs
    repeat (4) step(1'b0, rnd_words(), 1'($urandom), "R8");

    // R6 / R7: random vectors, each in both modes
    for (int i = 0; i < 400; i++) begin
      w = rnd_words();
      step(1'b1, w, 1'b1, "R4");
      step(1'b1, w, 1'b0, "R3");
      if (($urandom % 5) == 0) step(1'b0, rnd_words(), 1'($urandom), "R8");
    end
    repeat (4) step(1'b0, rnd_words(), 1'b0, "R8");

    chk(exp_q.size() == 0, "R2", exp_q.size(), 0);
    chk(abs_c < abs_d, "R7", abs_c, abs_d);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule